// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits in a PCI host bridge between a processor-side register bus and a downstream configuration bus. Software first writes a 32-bit configuration index into the index region. It then reads or writes the data region. For each data-region access, the block issues one configuration cycle whose address has been converted into a single normalized form.

The index can take one of three forms. In the enable form, bit 31 is set. In the type-1 form, bit 31 is clear and bit 0 is set. In the slot-select form, both bit 31 and bit 0 are clear and a one-hot bit among [31:11] picks the device. A slot-select index with no slot bit set addresses nothing.

The block also routes interrupts. It folds every device's four INTx pins onto the host's four interrupt lines using the standard rotation by device number.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset the index register reads 0, `cfg_req` is low, and `irq_out` is 0 while no interrupt input is high.
- R2: A write to the index region (`host_addr[12]`=0) updates only the bytes whose `host_be` bit is set. Lane 0 is bits [7:0] (little-endian). A read of the index region returns the index register.
- R3: In the enable form (index bit 31 = 1), a data-region access (`host_addr[12]`=1) drives `cfg_addr` = index OR `host_addr[1:0]`.
- R4: In the type-1 form (bit 31 = 0, bit 0 = 1), `cfg_addr` = index with bits [2:0] cleared, OR `host_addr[2:0]`.
- R5: In the slot-select form (bits 31 and 0 both 0), the slot is the position of the lowest set bit among index bits [31:11], minus 11. `cfg_addr` = {16'b0, slot[4:0], index[10:8], index[7:3], `host_addr[2:0]`}.
- R6: In the slot-select form with index bits [31:11] all clear, no cycle is issued (`cfg_req` stays low). A read returns 32'hFFFF_FFFF, and a write has no effect downstream.
- R7: For any valid data-region access, `cfg_req` is asserted in the same cycle, with `cfg_we` = write and with `host_wdata` and `host_be` passed through. A read returns `cfg_rdata`.
- R8: Interrupt pin N (0=INTA to 3=INTD) of device d, carried on `dev_int[4*d+N]`, drives `irq_out[(N+d) mod 4]`.
- R9: Each `irq_out` line is the combinational OR of all levels mapped onto it. A falling input releases its line when no other mapped input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Register-bus read strobe |
| host_wr | input | 1 | Register-bus write strobe |
| host_addr | input | 13 | Byte address; bit 12 selects the data region |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables |
| host_rdata | output | 32 | Read data, valid in the strobe cycle |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Configuration cycle is a write |
| cfg_addr | output | 32 | Normalized configuration address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_rdata | input | 32 | Configuration read data |
| dev_int | input | 128 | INTx levels, four per device |
| irq_out | output | 4 | Host interrupt lines |

## Verification
The bench sets two slot bits at once to confirm that the lowest one wins; a priority encoder built the wrong way round would report the higher slot. It uses slot bit 30 and slot bit 11 to expose off-by-one errors in the slot numbering. It uses an empty slot field to catch a design that issues a cycle to slot 0 or returns stale data instead of all ones. It also checks that the type-1 form clears index bits [2:0] before merging the offset, and that the enable form merges only two offset bits. Every device number from 0 to 31 is driven through the swizzle, so a missing or wrong rotation shows up as the wrong line rising.

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
  parameter int NDEV = 32,
  parameter int AW   = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic [31:0]       host_wdata,
  input  logic [3:0]        host_be,
  output logic [31:0]       host_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [31:0]       cfg_addr,
  output logic [31:0]       cfg_wdata,
  output logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_rdata,
  input  logic [NDEV*4-1:0] dev_int,
  output logic [3:0]        irq_out
);
  localparam int SEL = AW - 1;

  logic [31:0] idx_q;
  logic [4:0]  slot;
  logic        slot_ok;
  logic        in_data, fmt_en, fmt_t1, hit;
  logic [31:0] xaddr;

  assign in_data = host_addr[SEL];
  assign fmt_en  = idx_q[31];
  assign fmt_t1  = !idx_q[31] && idx_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (host_wr && !in_data)
      for (int b = 0; b < 4; b++)
        if (host_be[b]) idx_q[8*b +: 8] <= host_wdata[8*b +: 8];
  end

  always_comb begin
    slot    = '0;
    slot_ok = 1'b0;
    for (int i = 31; i >= 11; i--)
      if (idx_q[i]) begin
        slot    = 5'(i - 11);
        slot_ok = 1'b1;
      end
  end

  always_comb begin
    if (fmt_en)      xaddr = idx_q | {30'b0, host_addr[1:0]};
    else if (fmt_t1) xaddr = {idx_q[31:3], host_addr[2:0]};
    else             xaddr = {16'b0, slot, idx_q[10:8], idx_q[7:3], host_addr[2:0]};
  end

  assign hit       = in_data && (host_rd || host_wr) && (fmt_en || fmt_t1 || slot_ok);
  assign cfg_req   = hit;
  assign cfg_we    = host_wr;
  assign cfg_addr  = xaddr;
  assign cfg_wdata = host_wdata;
  assign cfg_be    = host_be;

  always_comb begin
    if (!in_data)  host_rdata = idx_q;
    else if (hit)  host_rdata = cfg_rdata;
    else           host_rdata = '1;
  end

  logic [3:0] line_or [NDEV];
  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    for (genvar l = 0; l < 4; l++) begin : g_line
      localparam int PIN = (l - (d % 4) + 4) % 4;
      assign line_or[d][l] = dev_int[4*d + PIN];
    end
  end

  always_comb begin
    irq_out = '0;
    for (int d = 0; d < NDEV; d++) irq_out |= line_or[d];
  end
endmodule

module cfg_addr_xlate_chk #(
  parameter int NDEV = 32,
  parameter int AW   = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd,
  input logic              host_wr,
  input logic [AW-1:0]     host_addr,
  input logic [31:0]       host_wdata,
  input logic [3:0]        host_be,
  input logic [31:0]       host_rdata,
  input logic              cfg_req,
  input logic [31:0]       cfg_addr,
  input logic [NDEV*4-1:0] dev_int,
  input logic [3:0]        irq_out,
  input logic [31:0]       idx_q
);
  a_r7_req_only_data: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (host_addr[AW-1] && (host_rd || host_wr)));
  a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr[AW-1] && host_be == 4'hF) |=> idx_q == $past(host_wdata));
  a_r6_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr[AW-1] && !idx_q[31] && !idx_q[0] && idx_q[31:11] == '0)
      |-> (!cfg_req && host_rdata == 32'hFFFF_FFFF));
  a_r3_enable_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && idx_q[31]) |-> cfg_addr[31:2] == idx_q[31:2]);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dev_int) == 0) |-> irq_out == 4'b0);
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dev_int) == 1) |-> $onehot0(irq_out) && irq_out != 4'b0);
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk #(.NDEV(NDEV), .AW(AW)) u_chk (.*);

// File: tb/tb_cfg_addr_xlate.sv
module tb_cfg_addr_xlate;
  logic clk = 0, rst_n = 0;
  logic host_rd = 0, host_wr = 0;
  logic [12:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata, cfg_addr, cfg_wdata, cfg_rdata;
  logic [3:0] host_be = '0, cfg_be, irq_out;
  logic cfg_req, cfg_we;
  logic [127:0] dev_int = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign cfg_rdata = cfg_addr ^ 32'h5A5A_0000;

  cfg_addr_xlate dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idx_wr(logic [31:0] v, logic [3:0] be);
    @(negedge clk);
    host_wr = 1; host_addr = 13'h0000; host_wdata = v; host_be = be;
    @(negedge clk);
    host_wr = 0; host_be = '0;
  endtask

  task automatic idx_rd(string req, logic [31:0] exp);
    @(negedge clk);
    host_rd = 1; host_addr = 13'h0004;
    #1 chk(req, host_rdata, exp);
    @(negedge clk) host_rd = 0;
  endtask

  task automatic data_rd(string req, logic [2:0] off, logic [31:0] exp_addr);
    @(negedge clk);
    host_rd = 1; host_addr = {1'b1, 9'h0, off};
    #1;
    chk({req, " req"}, {31'b0, cfg_req}, 32'd1);
    chk({req, " addr"}, cfg_addr, exp_addr);
    chk({req, " rdata"}, host_rdata, exp_addr ^ 32'h5A5A_0000);
    @(negedge clk) host_rd = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 req", {31'b0, cfg_req}, 0);
    chk("R1 irq", {28'b0, irq_out}, 0);
    idx_rd("R1 idx", 32'h0);
  endtask

  task automatic t_lanes;
    idx_wr(32'hAABB_CCDD, 4'b0101);
    idx_rd("R2 lanes", 32'h00BB_00DD);
    idx_wr(32'h1122_3344, 4'b1000);
    idx_rd("R2 lane3", 32'h11BB_00DD);
  endtask

  task automatic t_enable;
    idx_wr(32'h8000_0A10, 4'hF);
    data_rd("R3 enable", 3'd7, 32'h8000_0A13);
  endtask

  task automatic t_type1;
    idx_wr(32'h0001_2345, 4'hF);
    data_rd("R4 type1", 3'd2, 32'h0001_2342);
  endtask

  task automatic t_slot;
    idx_wr(32'h0010_45F8, 4'hF);
    data_rd("R5 lowest", 3'd6, 32'h0000_1DFE);
    idx_wr(32'h4000_0000, 4'hF);
    data_rd("R5 slot19", 3'd0, 32'h0000_9800);
    idx_wr(32'h0000_0800, 4'hF);
    data_rd("R5 slot0", 3'd1, 32'h0000_0001);
  endtask

  task automatic t_empty;
    idx_wr(32'h0000_0304, 4'hF);
    @(negedge clk);
    host_rd = 1; host_addr = 13'h1000;
    #1;
    chk("R6 rd noreq", {31'b0, cfg_req}, 0);
    chk("R6 ones", host_rdata, 32'hFFFF_FFFF);
    @(negedge clk);
    host_rd = 0; host_wr = 1; host_wdata = 32'h1234_5678; host_be = 4'hF;
    #1 chk("R6 wr noreq", {31'b0, cfg_req}, 0);
    @(negedge clk) host_wr = 0;
  endtask

  task automatic t_write;
    idx_wr(32'h8000_0100, 4'hF);
    @(negedge clk);
    host_wr = 1; host_addr = 13'h1002; host_wdata = 32'hCAFE_F00D; host_be = 4'b0011;
    #1;
    chk("R7 req", {31'b0, cfg_req}, 1);
    chk("R7 we", {31'b0, cfg_we}, 1);
    chk("R7 wdata", cfg_wdata, 32'hCAFE_F00D);
    chk("R7 be", {28'b0, cfg_be}, 32'h3);
    chk("R7 addr", cfg_addr, 32'h8000_0102);
    @(negedge clk) host_wr = 0;
  endtask

  task automatic t_swizzle;
    for (int d = 0; d < 32; d++) begin
      int p = (d * 7) % 4;
      @(negedge clk);
      dev_int = '0; dev_int[4*d + p] = 1'b1;
      #1 chk($sformatf("R8 dev%0d", d), {28'b0, irq_out}, 32'(4'b1 << ((p + d) % 4)));
    end
    @(negedge clk);
    dev_int = '0; dev_int[4*1 + 0] = 1; dev_int[4*2 + 3] = 1;
    #1 chk("R9 or", {28'b0, irq_out}, 32'h2);
    dev_int[4*1 + 0] = 0;
    #1 chk("R9 hold", {28'b0, irq_out}, 32'h2);
    dev_int[4*2 + 3] = 0;
    #1 chk("R9 fall", {28'b0, irq_out}, 32'h0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lanes();
    t_enable();
    t_type1();
    t_slot();
    t_empty();
    t_write();
    t_swizzle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule